// File: doc/BRIEF.md
# Debug Bus Scan and Chip-Select Controller

This block sits on the slow debug bus of a multi-chip module and lets a test host reach one chip at a time. All debug bus lines arrive with no fixed relation to the system clock. The block passes them through a multi-stage synchronizer and acts once per rising edge of the bus strobe line. A small address register is shifted in over the data-in line and decoded into one select for this chip and three selects for its slaves. When this chip is the one addressed, the host can shift a serial chain. The chain holds a read-only identity word, a 52-bit data path section and two 4-bit clock-skew tap settings, and the host writes the tap settings this way at power-up.

The host also holds the system in freeze through a level line. It can then release it for exactly one system clock cycle with a step command. A reset command puts the address and the chain back to their start values. Several commands raised on the same strobe are resolved by a fixed priority.

Top module: `dbg_scan_ctrl`

## Requirements
- R1: A command takes effect on the outputs after the third rising system clock edge that follows the rising edge of the strobe (two synchronizer stages plus one action register). Before that, the outputs keep their earlier values.
- R2: After the reset input, or after a reset command, the address is 0, the data path section is all zero, and both skew outputs read 8 (the middle of 16 taps).
- R3: An address command shifts the data-in value into the address register from the top, so two strobes load bit 0 first and bit 1 second. While the chip-select input is high, address value k drives `chip_sel_o[k]` alone: bit 0 selects this chip and bits 1 to 3 select the slaves. While it is low, all selects are 0.
- R4: The chain is 76 bits long. `dbg_dout_o` shows chain bit 0 while this chip is selected, and 0 otherwise. Each shift moves every bit one place toward bit 0 and puts data-in into bit 75. Bits 0-15 are the identity word, bits 16-67 are the data path (`dp_o`), bits 68-71 are the internal skew and bits 72-75 are the external skew.
- R5: The identity word has the pattern in bits 0-3, the type in bits 4-9 and the version in bits 10-15. Every reset command and every address command reloads it from its parameters, so data that is shifted into it never survives the next of those commands.
- R6: A shift or step command is ignored when the address is not 0. The chain and the freeze output stay unchanged.
- R7: While freeze is held, a step command drives `freeze_o` low for exactly one cycle. Without freeze, a step command has no effect.
- R8: When several command lines are high at the same strobe, reset wins over address, address wins over shift, and shift wins over step.
- R9: While the chip-select input is low, strobes have no effect at all.
- R10: `freeze_o` follows the freeze line with two cycles of synchronizer delay.
- R11: After 76 shifts, the data path and skew outputs hold the 60 bits that were last shifted in, each at the position given in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_cs_i | input | 1 | Debug bus select for this module (asynchronous) |
| dbg_stb_i | input | 1 | Command strobe; acts on rising edge (asynchronous) |
| dbg_freeze_i | input | 1 | Freeze level (asynchronous) |
| dbg_rst_i | input | 1 | Reset command line |
| dbg_addr_i | input | 1 | Address-load command line |
| dbg_shift_i | input | 1 | Shift command line |
| dbg_exec_i | input | 1 | Single-step command line |
| dbg_din_i | input | 1 | Serial data in |
| dbg_dout_o | output | 1 | Serial data out |
| chip_sel_o | output | 4 | One-hot chip selects, bit 0 is this chip |
| freeze_o | output | 1 | Freeze to the system logic |
| skew_int_o | output | 4 | Internal clock skew tap setting |
| skew_ext_o | output | 4 | External clock skew tap setting |
| dp_o | output | 52 | Data path section of the chain |

## Verification
The bench keeps the default widths: a 2-bit address, a 52-bit data path, 4-bit skews and two synchronizer stages. With these widths the full 76-bit chain can be walked end to end in a few hundred strobes. It overrides the identity parameters with a pattern, type and version whose bits differ in every field, so that a swapped or reversed field shows up in the serial output. With two stages, the three-edge command latency and the one-cycle step pulse can be checked at exact cycles.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    // Identity word field widths; the pattern leaves the chain first.
    localparam int ID_PAT_W  = 4;
    localparam int ID_TYPE_W = 6;
    localparam int ID_VER_W  = 6;
    localparam int ID_W      = ID_PAT_W + ID_TYPE_W + ID_VER_W;

    // Synchronized debug bus lines, kept together as one bundle.
    typedef struct packed {
        logic cs;
        logic stb;
        logic frz;
        logic cmd_rst;
        logic cmd_addr;
        logic cmd_shift;
        logic cmd_exec;
        logic din;
    } dbg_in_t;

    localparam int DBG_IN_W = $bits(dbg_in_t);

    // Action decided for one strobe edge.
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_ADDR,
        ACT_SHIFT,
        ACT_STEP
    } act_e;

endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage[STAGES-1];

endmodule

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode #(
    parameter int ADDR_BITS = 2,
    localparam int NUM_SEL  = 1 << ADDR_BITS
) (
    input  logic                 en_i,
    input  logic [ADDR_BITS-1:0] addr_i,
    output logic [NUM_SEL-1:0]   sel_o
);

    // One select per address value; index 0 is the controller's own chip.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_o[g] = en_i && (addr_i == ADDR_BITS'(g));
    end

endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
    import dbg_pkg::*;
#(
    parameter int                   DP_BITS    = 52,
    parameter int                   SKEW_BITS  = 4,
    parameter int                   SKEW_RESET = 8,
    parameter logic [ID_PAT_W-1:0]  ID_PATTERN = 4'hA,
    parameter logic [ID_TYPE_W-1:0] ID_TYPE    = 6'h01,
    parameter logic [ID_VER_W-1:0]  ID_VERSION = 6'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  act_e                 act_i,
    input  logic                 din_i,
    output logic                 tail_o,
    output logic [DP_BITS-1:0]   dp_o,
    output logic [SKEW_BITS-1:0] skew_int_o,
    output logic [SKEW_BITS-1:0] skew_ext_o
);

    localparam int CH_LEN = ID_W + DP_BITS + 2 * SKEW_BITS;
    localparam int DP_LO  = ID_W;
    localparam int INT_LO = DP_LO + DP_BITS;
    localparam int EXT_LO = INT_LO + SKEW_BITS;
    localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_TYPE, ID_PATTERN};

    typedef struct packed {
        logic [CH_LEN-1:0] chain;
    } chain_t;

    chain_t st_d, st_q;

    function automatic logic [CH_LEN-1:0] start_chain();
        logic [CH_LEN-1:0] v;
        v = '0;
        v[ID_W-1:0]              = ID_VALUE;
        v[INT_LO +: SKEW_BITS]   = SKEW_BITS'(SKEW_RESET);
        v[EXT_LO +: SKEW_BITS]   = SKEW_BITS'(SKEW_RESET);
        return v;
    endfunction

    always_comb begin
        st_d = st_q;
        unique case (act_i)
            ACT_RESET: st_d.chain = start_chain();
            ACT_ADDR:  st_d.chain[ID_W-1:0] = ID_VALUE;
            ACT_SHIFT: st_d.chain = {din_i, st_q.chain[CH_LEN-1:1]};
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= start_chain();
        end else begin
            st_q <= st_d;
        end
    end

    assign tail_o     = st_q.chain[0];
    assign dp_o       = st_q.chain[DP_LO +: DP_BITS];
    assign skew_int_o = st_q.chain[INT_LO +: SKEW_BITS];
    assign skew_ext_o = st_q.chain[EXT_LO +: SKEW_BITS];

    // R2
    skew_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == ACT_RESET |=> (skew_int_o == SKEW_BITS'(SKEW_RESET)) &&
                               (skew_ext_o == SKEW_BITS'(SKEW_RESET)) && (dp_o == '0));

    // R5
    id_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_ADDR || act_i == ACT_RESET) |=> st_q.chain[ID_W-1:0] == ID_VALUE);

    // R4
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == ACT_SHIFT |=> st_q.chain[CH_LEN-1] == $past(din_i));

    // R6
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_NONE || act_i == ACT_STEP) |=> $stable(st_q.chain));

endmodule

// File: rtl/dbg_scan_ctrl.sv
module dbg_scan_ctrl
    import dbg_pkg::*;
#(
    parameter int                   ADDR_BITS   = 2,
    parameter int                   SYNC_STAGES = 2,
    parameter int                   DP_BITS     = 52,
    parameter int                   SKEW_BITS   = 4,
    parameter int                   SKEW_RESET  = 8,
    parameter logic [ID_PAT_W-1:0]  ID_PATTERN  = 4'hA,
    parameter logic [ID_TYPE_W-1:0] ID_TYPE     = 6'h01,
    parameter logic [ID_VER_W-1:0]  ID_VERSION  = 6'h01,
    localparam int                  NUM_SEL     = 1 << ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dbg_cs_i,
    input  logic                 dbg_stb_i,
    input  logic                 dbg_freeze_i,
    input  logic                 dbg_rst_i,
    input  logic                 dbg_addr_i,
    input  logic                 dbg_shift_i,
    input  logic                 dbg_exec_i,
    input  logic                 dbg_din_i,
    output logic                 dbg_dout_o,
    output logic [NUM_SEL-1:0]   chip_sel_o,
    output logic                 freeze_o,
    output logic [SKEW_BITS-1:0] skew_int_o,
    output logic [SKEW_BITS-1:0] skew_ext_o,
    output logic [DP_BITS-1:0]   dp_o
);

    typedef struct packed {
        logic                 stb_prev;
        logic [ADDR_BITS-1:0] addr;
        logic                 step;
    } ctl_t;

    dbg_in_t raw, syn;
    ctl_t    st_d, st_q;
    act_e    act;
    logic    stb_edge;
    logic    self_sel;
    logic    tail;

    assign raw = '{cs:        dbg_cs_i,
                   stb:       dbg_stb_i,
                   frz:       dbg_freeze_i,
                   cmd_rst:   dbg_rst_i,
                   cmd_addr:  dbg_addr_i,
                   cmd_shift: dbg_shift_i,
                   cmd_exec:  dbg_exec_i,
                   din:       dbg_din_i};

    dbg_sync #(
        .W      (DBG_IN_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (syn)
    );

    always_comb begin
        st_d     = st_q;
        stb_edge = syn.stb && !st_q.stb_prev;
        self_sel = syn.cs && (st_q.addr == '0);
        act      = ACT_NONE;
        if (stb_edge && syn.cs) begin
            if (syn.cmd_rst) begin
                act = ACT_RESET;
            end else if (syn.cmd_addr) begin
                act = ACT_ADDR;
            end else if (syn.cmd_shift && self_sel) begin
                act = ACT_SHIFT;
            end else if (syn.cmd_exec && self_sel) begin
                act = ACT_STEP;
            end
        end
        st_d.stb_prev = syn.stb;
        st_d.step     = (act == ACT_STEP) && syn.frz;
        if (act == ACT_RESET) begin
            st_d.addr = '0;
        end else if (act == ACT_ADDR) begin
            st_d.addr = (st_q.addr >> 1) | (ADDR_BITS'(syn.din) << (ADDR_BITS - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dbg_addr_decode #(
        .ADDR_BITS (ADDR_BITS)
    ) i_decode (
        .en_i   (syn.cs),
        .addr_i (st_q.addr),
        .sel_o  (chip_sel_o)
    );

    dbg_scan_chain #(
        .DP_BITS    (DP_BITS),
        .SKEW_BITS  (SKEW_BITS),
        .SKEW_RESET (SKEW_RESET),
        .ID_PATTERN (ID_PATTERN),
        .ID_TYPE    (ID_TYPE),
        .ID_VERSION (ID_VERSION)
    ) i_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act),
        .din_i      (syn.din),
        .tail_o     (tail),
        .dp_o       (dp_o),
        .skew_int_o (skew_int_o),
        .skew_ext_o (skew_ext_o)
    );

    assign dbg_dout_o = self_sel && tail;
    assign freeze_o   = syn.frz && !st_q.step;

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_sel_o));

    // R7
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step |=> !st_q.step);

    // R8
    reset_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_edge && syn.cs && syn.cmd_rst) |=> (st_q.addr == '0));

    // R9
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !syn.cs |-> act == ACT_NONE);

endmodule

// File: tb/test_dbg_scan_ctrl.sv
module test_dbg_scan_ctrl;
    import dbg_pkg::*;

    localparam logic [3:0] T_PAT = 4'h9;
    localparam logic [5:0] T_TYP = 6'h2D;
    localparam logic [5:0] T_VER = 6'h13;
    localparam logic [15:0] T_ID = {T_VER, T_TYP, T_PAT};
    localparam int CH = 76;

    logic clk = 0;
    logic rst_n = 0;
    logic cs = 0, stb = 0, frz = 0, c_rst = 0, c_addr = 0, c_shift = 0, c_exec = 0, din = 0;
    logic        dout;
    logic [3:0]  sel;
    logic        frz_o;
    logic [3:0]  sk_i, sk_e;
    logic [51:0] dp;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dbg_scan_ctrl #(
        .ID_PATTERN (T_PAT),
        .ID_TYPE    (T_TYP),
        .ID_VERSION (T_VER)
    ) i_dbg_scan_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_cs_i     (cs),
        .dbg_stb_i    (stb),
        .dbg_freeze_i (frz),
        .dbg_rst_i    (c_rst),
        .dbg_addr_i   (c_addr),
        .dbg_shift_i  (c_shift),
        .dbg_exec_i   (c_exec),
        .dbg_din_i    (din),
        .dbg_dout_o   (dout),
        .chip_sel_o   (sel),
        .freeze_o     (frz_o),
        .skew_int_o   (sk_i),
        .skew_ext_o   (sk_e),
        .dp_o         (dp)
    );

    // Behavioural reference model
    dbg_in_t m_pipe [2];
    bit      m_prev;
    int      m_addr;
    bit      m_step;
    bit      m_chain [$];

    task automatic model_restart();
        m_chain.delete();
        for (int i = 0; i < CH; i++) m_chain.push_back(1'b0);
        for (int i = 0; i < 16; i++) m_chain[i] = T_ID[i];
        for (int i = 0; i < 4; i++) begin
            m_chain[68 + i] = (i == 3);
            m_chain[72 + i] = (i == 3);
        end
        m_addr = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pipe[0] = '0;
            m_pipe[1] = '0;
            m_prev = 0;
            m_step = 0;
            model_restart();
        end else begin
            bit e, me, nstep;
            e = m_pipe[1].stb && !m_prev;
            me = m_pipe[1].cs && (m_addr == 0);
            nstep = 0;
            if (e && m_pipe[1].cs) begin
                if (m_pipe[1].cmd_rst) model_restart();
                else if (m_pipe[1].cmd_addr) begin
                    m_addr = (m_addr >> 1) | (int'(m_pipe[1].din) << 1);
                    for (int i = 0; i < 16; i++) m_chain[i] = T_ID[i];
                end else if (m_pipe[1].cmd_shift && me) begin
                    void'(m_chain.pop_front());
                    m_chain.push_back(m_pipe[1].din);
                end else if (m_pipe[1].cmd_exec && me) nstep = m_pipe[1].frz;
            end
            m_step = nstep;
            m_prev = m_pipe[1].stb;
            m_pipe[1] = m_pipe[0];
            m_pipe[0] = '{cs: cs, stb: stb, frz: frz, cmd_rst: c_rst, cmd_addr: c_addr,
                          cmd_shift: c_shift, cmd_exec: c_exec, din: din};
        end
    end

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0]  e_sel, e_si, e_se;
            logic [51:0] e_dp;
            e_sel = m_pipe[1].cs ? (4'b1 << m_addr) : 4'b0;
            for (int i = 0; i < 4; i++) begin
                e_si[i] = m_chain[68 + i];
                e_se[i] = m_chain[72 + i];
            end
            for (int i = 0; i < 52; i++) e_dp[i] = m_chain[16 + i];
            check("R3 chip_sel_o", 64'(sel), 64'(e_sel));
            check("R4 dbg_dout_o", 64'(dout), 64'(m_pipe[1].cs && m_addr == 0 && m_chain[0]));
            check("R7 freeze_o", 64'(frz_o), 64'(m_pipe[1].frz && !m_step));
            check("R11 skew_int_o", 64'(sk_i), 64'(e_si));
            check("R11 skew_ext_o", 64'(sk_e), 64'(e_se));
            check("R4 dp_o", 64'(dp), 64'(e_dp));
        end
    end

    task automatic strobe(bit r, bit a, bit s, bit x, bit d);
        @(negedge clk);
        c_rst = r; c_addr = a; c_shift = s; c_exec = x; din = d;
        stb = 1;
        repeat (4) @(negedge clk);
        stb = 0;
        repeat (4) @(negedge clk);
        c_rst = 0; c_addr = 0; c_shift = 0; c_exec = 0;
    endtask

    task automatic load_addr(int a);
        strobe(0, 1, 0, 0, a[0]);
        strobe(0, 1, 0, 0, a[1]);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [75:0] pat;
        logic [3:0]  old_si;
        int          lows;
        for (int i = 0; i < CH; i++) pat[i] = ((i * 7 + 3) % 5) < 2;

        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 reset skew_int", 64'(sk_i), 64'd8);
        check("R2 reset skew_ext", 64'(sk_e), 64'd8);
        check("R2 reset dp", 64'(dp), 64'd0);
        rst_n = 1;
        @(negedge clk);
        cs = 1;
        repeat (4) @(negedge clk);
        // R3: address 0 selects this chip
        check("R3 self select", 64'(sel), 64'b0001);

        // R4 R5: identity word leaves the chain first, pattern bits lowest
        for (int k = 0; k < CH; k++) begin
            if (k < 16) check("R5 id bit out", 64'(dout), 64'(T_ID[k]));
            strobe(0, 0, 1, 0, pat[k]);
        end
        // R11: data path and skews hold the shifted pattern
        check("R11 dp after fill", 64'(dp), 64'(pat[67:16]));
        check("R11 int skew after fill", 64'(sk_i), 64'(pat[71:68]));
        check("R11 ext skew after fill", 64'(sk_e), 64'(pat[75:72]));

        // R5: address load reloads the identity word
        load_addr(0);
        for (int k = 0; k < 16; k++) begin
            check("R5 id reload", 64'(dout), 64'(T_ID[k]));
            strobe(0, 0, 1, 0, 1'b0);
        end

        // R3 R6: select slave 2, shift ignored
        load_addr(2);
        check("R3 slave select", 64'(sel), 64'b0100);
        check("R4 dout quiet when slave", 64'(dout), 64'd0);
        old_si = sk_i;
        strobe(0, 0, 1, 0, 1'b1);
        strobe(0, 0, 1, 0, 1'b0);
        check("R6 shift ignored", 64'(sk_i), 64'(old_si));

        // R9: deselected strobes do nothing
        cs = 0;
        repeat (4) @(negedge clk);
        check("R9 no select", 64'(sel), 64'd0);
        strobe(1, 0, 0, 0, 1'b0);
        cs = 1;
        repeat (4) @(negedge clk);
        check("R9 reset ignored", 64'(sk_i), 64'(old_si));
        check("R9 address kept", 64'(sel), 64'b0100);
        load_addr(0);

        // R10: freeze latency of two edges
        frz = 1;
        @(negedge clk);
        check("R10 freeze after one edge", 64'(frz_o), 64'd0);
        @(negedge clk);
        check("R10 freeze after two edges", 64'(frz_o), 64'd1);

        // R7: one-cycle release
        @(negedge clk);
        c_exec = 1; stb = 1;
        lows = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!frz_o) lows++;
        end
        stb = 0; c_exec = 0;
        repeat (4) @(negedge clk);
        check("R7 step pulse width", 64'(lows), 64'd1);
        frz = 0;
        repeat (4) @(negedge clk);
        strobe(0, 0, 0, 1, 1'b0);
        check("R7 step without freeze", 64'(frz_o), 64'd0);

        // R1 R8: reset wins over other commands; three-edge latency
        old_si = sk_i;
        c_rst = 1; c_addr = 1; c_shift = 1; c_exec = 1; din = 1;
        stb = 1;
        @(negedge clk);
        check("R1 unchanged after edge 1", 64'(sk_i), 64'(old_si));
        @(negedge clk);
        check("R1 unchanged after edge 2", 64'(sk_i), 64'(old_si));
        @(negedge clk);
        check("R1 applied after edge 3", 64'(sk_i), 64'd8);
        repeat (2) @(negedge clk);
        stb = 0;
        c_rst = 0; c_addr = 0; c_shift = 0; c_exec = 0;
        repeat (4) @(negedge clk);
        check("R8 reset priority select", 64'(sel), 64'b0001);
        check("R8 reset priority ext skew", 64'(sk_e), 64'd8);
        check("R2 reset cmd dp", 64'(dp), 64'd0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule